// File: doc/BRIEF.md
# Bus-Mastering Thermal Sampling Sequencer

This block gathers temperature readings from up to four sensing points without owning a converter. It shares an analog-to-digital converter that sits elsewhere on the chip, and it reaches that converter and the sensor selector through a simple single-outstanding bus master port. A timebase built from a programmable prescaler starts a sampling round at a fixed period. In each round the block visits the active points in index order. For each point it writes the point's selector code, starts a conversion, polls a status word until a programmable valid bit shows the wanted level, then reads the data word and keeps its low 12 bits.

All settings arrive as plain configuration inputs and are expected to stay stable while the block is enabled. These settings are the prescaler unit, the round and inter-point intervals, the poll spacing and limit, the selector codes, the write enables, the valid-bit position and level, and the bus addresses. Each point has a 12-bit result, a one-cycle update strobe and an error flag. The error flag is set when the point runs out of polls.

Top module: `thermal_seq`

## Requirements
- R1: After reset all results read zero, every error flag and update strobe is low, and no bus request is raised.
- R2: While `en` is high, a round begins once every `cfg_sen_int` base ticks, and one base tick lasts (`cfg_unit`+1)×256 clock cycles. Successive rounds therefore start exactly `cfg_sen_int`×(`cfg_unit`+1)×256 cycles apart. While `en` is low, no request is raised.
- R3: Each point starts with optional writes, in this order. When `cfg_wr_ctl` bit 0 is set, the point's code goes to `cfg_pnp_addr`. When bit 1 is set, the code goes to `cfg_mux_addr`. A write of a word with only bit 11 set to `cfg_en_addr` always follows. Point p's code is `cfg_codes[p*5 +: 5]`.
- R4: A request holds its address, direction and write data unchanged until `bus_ack`, and only one transaction is in flight.
- R5: After the start write, the block reads `cfg_stat_addr`. A status read is valid when bit `cfg_valid_ctl[4:0]` of the read word equals `cfg_valid_ctl[5]`. After an invalid read, the next status request is raised `cfg_poll_int` cycles after the acknowledge edge.
- R6: After a valid status, one read of `cfg_data_addr` follows. Its bits 11:0 become that point's result, and that point's `res_upd` bit pulses for one cycle.
- R7: When `cfg_max_polls` status reads are all invalid, the point ends with no data read, its result kept and its error flag set. A limit of 0 acts as 1.
- R8: The points visited are 0 up to `cfg_npts`−1. A count of 0 visits only point 0, and a count above 4 visits all four points.
- R9: Between the end of one point and the start of the next, the block waits until `cfg_filt_int` base ticks have passed.
- R10: An error flag stays set until that same point next completes a valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears timers and the sequencer |
| cfg_unit | input | 10 | Prescaler: base tick = (value+1)×256 cycles |
| cfg_sen_int | input | 10 | Round period in base ticks |
| cfg_filt_int | input | 10 | Gap between points in base ticks |
| cfg_poll_int | input | 16 | Cycles between status reads |
| cfg_max_polls | input | 8 | Status reads allowed per point |
| cfg_npts | input | 3 | Number of active points |
| cfg_wr_ctl | input | 2 | bit0 code write to pnp address, bit1 code write to mux address |
| cfg_valid_ctl | input | 6 | bits 4:0 valid-bit position, bit 5 valid level |
| cfg_codes | input | 20 | Four 5-bit selector codes, point 0 in the low bits |
| cfg_pnp_addr | input | 16 | Target of the first code write |
| cfg_mux_addr | input | 16 | Target of the second code write |
| cfg_en_addr | input | 16 | Converter start register |
| cfg_stat_addr | input | 16 | Status word address |
| cfg_data_addr | input | 16 | Data word address |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 16 | Transaction address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| res_data | output | 48 | Four 12-bit results, point 0 in the low bits |
| res_upd | output | 4 | One-cycle strobe per updated point |
| res_err | output | 4 | Per-point timeout flag |

## Verification
The assertions assume a responder that raises `bus_ack` only while a request is pending and never for two cycles in a row. They also assume that the configuration does not change and `en` does not fall while a transaction is open. The bench's responder acknowledges on the falling edge one cycle after a request appears and drops the acknowledge at the next falling edge. The bench changes settings only while `en` is low. It lowers `en` only after every expected transaction of a round has been seen, so a transfer is never cut off.

// File: rtl/thermal_seq.sv
module thermal_seq #(
  parameter int NPTS   = 4,
  parameter int UW     = 10,
  parameter int PIW    = 16,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int CW     = 5,
  parameter int RW     = 12,
  parameter int ADC_CH = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [UW-1:0]        cfg_unit,
  input  logic [UW-1:0]        cfg_sen_int,
  input  logic [UW-1:0]        cfg_filt_int,
  input  logic [PIW-1:0]       cfg_poll_int,
  input  logic [7:0]           cfg_max_polls,
  input  logic [$clog2(NPTS+1)-1:0] cfg_npts,
  input  logic [1:0]           cfg_wr_ctl,
  input  logic [5:0]           cfg_valid_ctl,
  input  logic [NPTS*CW-1:0]   cfg_codes,
  input  logic [AW-1:0]        cfg_pnp_addr,
  input  logic [AW-1:0]        cfg_mux_addr,
  input  logic [AW-1:0]        cfg_en_addr,
  input  logic [AW-1:0]        cfg_stat_addr,
  input  logic [AW-1:0]        cfg_data_addr,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [AW-1:0]        bus_addr,
  output logic [DW-1:0]        bus_wdata,
  input  logic                 bus_ack,
  input  logic [DW-1:0]        bus_rdata,
  output logic [NPTS*RW-1:0]   res_data,
  output logic [NPTS-1:0]      res_upd,
  output logic [NPTS-1:0]      res_err
);
  localparam int PW = UW + 9;
  localparam int IW = (NPTS > 1) ? $clog2(NPTS) : 1;
  localparam int NW = $clog2(NPTS + 1);

  typedef enum logic [2:0] {IDLE, PNP, MUX, START, WAIT, POLL, READ, GAP} st_t;

  st_t            st, st_first;
  logic [PW-1:0]  pre;
  logic [UW-1:0]  rnd, fcnt;
  logic           go;
  logic [IW-1:0]  pt, last_pt;
  logic [PIW-1:0] pcnt;
  logic [7:0]     npoll;
  logic [RW-1:0]  res [NPTS];

  wire          tick     = (pre == {1'b0, cfg_unit, 8'hFF});
  wire [CW-1:0] code     = cfg_codes[int'(pt)*CW +: CW];
  wire          hit      = (bus_rdata[cfg_valid_ctl[4:0]] == cfg_valid_ctl[5]);
  wire          last     = (pt == last_pt);
  wire          poll_out = ({1'b0, npoll} + 9'd1 >= {1'b0, cfg_max_polls});

  assign st_first = cfg_wr_ctl[0] ? PNP : (cfg_wr_ctl[1] ? MUX : START);

  always_comb begin
    if (cfg_npts == '0)                 last_pt = '0;
    else if (cfg_npts >= NW'(NPTS))     last_pt = IW'(NPTS - 1);
    else                                last_pt = IW'(cfg_npts - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      pre <= '0;
      rnd <= '0;
      go  <= 1'b0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (st == IDLE && go) go <= 1'b0;
      if (tick) begin
        if ({1'b0, rnd} + 1'b1 >= {1'b0, cfg_sen_int}) begin
          rnd <= '0;
          go  <= 1'b1;
        end else rnd <= rnd + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; pt <= '0; pcnt <= '0; npoll <= '0; fcnt <= '0;
      res_upd <= '0; res_err <= '0;
      for (int i = 0; i < NPTS; i++) res[i] <= '0;
    end else begin
      res_upd <= '0;
      if (!en) st <= IDLE;
      else case (st)
        IDLE:  if (go) begin pt <= '0; st <= st_first; end
        PNP:   if (bus_ack) st <= cfg_wr_ctl[1] ? MUX : START;
        MUX:   if (bus_ack) st <= START;
        START: if (bus_ack) begin st <= WAIT; pcnt <= '0; npoll <= '0; end
        WAIT:  if ({1'b0, pcnt} + 1'b1 >= {1'b0, cfg_poll_int}) st <= POLL;
               else pcnt <= pcnt + 1'b1;
        POLL:  if (bus_ack) begin
                 npoll <= npoll + 1'b1;
                 if (hit) st <= READ;
                 else if (poll_out) begin
                   res_err[pt] <= 1'b1;
                   st <= last ? IDLE : GAP;
                   fcnt <= '0;
                 end else begin
                   st <= WAIT; pcnt <= '0;
                 end
               end
        READ:  if (bus_ack) begin
                 res[pt]     <= bus_rdata[RW-1:0];
                 res_upd[pt] <= 1'b1;
                 res_err[pt] <= 1'b0;
                 st <= last ? IDLE : GAP;
                 fcnt <= '0;
               end
        GAP:   if (fcnt >= cfg_filt_int) begin pt <= pt + 1'b1; st <= st_first; end
               else if (tick) fcnt <= fcnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    case (st)
      PNP:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = cfg_pnp_addr; bus_wdata = DW'(code); end
      MUX:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = cfg_mux_addr; bus_wdata = DW'(code); end
      START: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = cfg_en_addr;  bus_wdata = DW'(1) << ADC_CH; end
      POLL:  begin bus_req = 1'b1; bus_addr = cfg_stat_addr; end
      READ:  begin bus_req = 1'b1; bus_addr = cfg_data_addr; end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NPTS; g++) begin : g_res
    assign res_data[g*RW +: RW] = res[g];
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bus_req);

  // R6
  upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|res_upd) |-> ($onehot0(res_upd) && $past(bus_ack && !bus_we)));

  // R7
  err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(res_err & ~$past(res_err))) |-> $past(bus_ack && !bus_we && bus_addr == cfg_stat_addr));
endmodule

// File: tb/tb_thermal_seq.sv
module tb_thermal_seq;
  localparam int NPTS = 4, AW = 16, DW = 32, CW = 5;
  localparam logic [AW-1:0] A_PNP = 16'h0100, A_MUX = 16'h0104, A_GO = 16'h0200,
                            A_ST = 16'h0208, A_DAT = 16'h020C;

  logic clk = 0, rst_n = 0, en = 0;
  always #10 clk = ~clk;

  logic [9:0] cfg_unit = 0, cfg_sen_int = 4, cfg_filt_int = 0;
  logic [15:0] cfg_poll_int = 3;
  logic [7:0] cfg_max_polls = 4;
  logic [2:0] cfg_npts = 4;
  logic [1:0] cfg_wr_ctl = 3;
  logic [5:0] cfg_valid_ctl = 6'b1_00111;
  logic [NPTS*CW-1:0] cfg_codes = {5'd16, 5'd3, 5'd1, 5'd0};
  logic bus_req, bus_we, bus_ack = 0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = 0;
  logic [NPTS*12-1:0] res_data;
  logic [NPTS-1:0] res_upd, res_err;

  thermal_seq dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_unit(cfg_unit), .cfg_sen_int(cfg_sen_int), .cfg_filt_int(cfg_filt_int),
    .cfg_poll_int(cfg_poll_int), .cfg_max_polls(cfg_max_polls), .cfg_npts(cfg_npts),
    .cfg_wr_ctl(cfg_wr_ctl), .cfg_valid_ctl(cfg_valid_ctl), .cfg_codes(cfg_codes),
    .cfg_pnp_addr(A_PNP), .cfg_mux_addr(A_MUX), .cfg_en_addr(A_GO),
    .cfg_stat_addr(A_ST), .cfg_data_addr(A_DAT),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .res_data(res_data), .res_upd(res_upd), .res_err(res_err));

  typedef struct {bit we; logic [AW-1:0] addr; logic [DW-1:0] data; bit rf; bit pf;} item_t;
  item_t exp_q[$];
  int rstart[$];
  int nvec = 0, nfail = 0, cyc = 0;
  int need[NPTS];
  logic [11:0] val[NPTS], exp_res[NPTS];
  bit exp_err[NPTS];
  int en_seen = 0, pc = 0, prev_cyc = 0, last_gap = 0, upd_seen = 0, upd_exp = 0, req_seen = 0;
  bit prev_st = 0;

  always @(posedge clk) cyc++;

  task automatic fail(string r, string what, longint act, longint exp);
    nfail++;
    $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
  endtask

  task automatic chk(string r, string what, longint act, longint exp);
    nvec++;
    if (act !== exp) fail(r, what, act, exp);
  endtask

  function automatic int neff();
    return (cfg_npts == 0) ? 1 : ((cfg_npts > NPTS) ? NPTS : int'(cfg_npts));
  endfunction

  // monitor and bus responder
  always @(negedge clk) begin : mon
    item_t e;
    int p;
    if (rst_n && |res_upd) upd_seen += $countones(res_upd);
    if (bus_req) req_seen++;
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      p = (en_seen > 0) ? (en_seen - 1) % neff() : 0;
      if (bus_we && bus_addr == A_GO) begin en_seen++; pc = 0; end
      if (!bus_we && bus_addr == A_ST) begin
        logic [DW-1:0] w;
        pc++;
        w = 32'h5A5A_5A5A;
        w[cfg_valid_ctl[4:0]] = (pc >= need[p]) ? cfg_valid_ctl[5] : ~cfg_valid_ctl[5];
        bus_rdata <= w;
      end else bus_rdata <= {20'hFEDCB, val[p]};
      if (exp_q.size() == 0) fail("R3", "unexpected transaction at address", bus_addr, 0);
      else begin
        e = exp_q.pop_front();
        nvec++;
        if (e.we !== bus_we || e.addr !== bus_addr || (e.we && e.data !== bus_wdata))
          fail("R3", "transaction addr/data", {bus_we, bus_addr, bus_wdata}, {e.we, e.addr, e.data});
        if (e.rf) rstart.push_back(cyc);
        if (e.pf) last_gap = cyc - prev_cyc;
        if (!bus_we && bus_addr == A_ST && prev_st)
          chk("R5", "status poll spacing", cyc - prev_cyc, cfg_poll_int + 1);
      end
      prev_st = !bus_we && bus_addr == A_ST;
      prev_cyc = cyc;
    end else bus_ack <= 1'b0;
  end

  task automatic push(bit we, logic [AW-1:0] a, logic [DW-1:0] d, inout bit first, input int p);
    item_t it;
    it.we = we; it.addr = a; it.data = d;
    it.rf = first && p == 0; it.pf = first && p > 0;
    first = 0;
    exp_q.push_back(it);
  endtask

  // driver: expected transactions and results of one round
  task automatic push_round();
    int mp = (cfg_max_polls == 0) ? 1 : int'(cfg_max_polls);
    for (int p = 0; p < neff(); p++) begin
      bit first = 1;
      logic [DW-1:0] c = DW'(cfg_codes[p*CW +: CW]);
      int k = (need[p] < mp) ? need[p] : mp;
      if (cfg_wr_ctl[0]) push(1, A_PNP, c, first, p);
      if (cfg_wr_ctl[1]) push(1, A_MUX, c, first, p);
      push(1, A_GO, 32'h0000_0800, first, p);
      for (int j = 0; j < k; j++) push(0, A_ST, '0, first, p);
      if (need[p] <= mp) begin
        push(0, A_DAT, '0, first, p);
        exp_res[p] = val[p]; exp_err[p] = 0; upd_exp++;
      end else exp_err[p] = 1;
    end
  endtask

  task automatic run(int rounds, string r);
    en_seen = 0; pc = 0; upd_seen = 0; upd_exp = 0; prev_st = 0;
    rstart.delete();
    for (int i = 0; i < rounds; i++) push_round();
    @(negedge clk); en = 1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int p = 0; p < NPTS; p++) begin
      chk("R6", $sformatf("%s result of point %0d", r, p), res_data[p*12 +: 12], exp_res[p]);
      chk("R7", $sformatf("%s error flag of point %0d", r, p), res_err[p], exp_err[p]);
    end
    chk("R6", {r, " update strobe count"}, upd_seen, upd_exp);
    en = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fail("R2", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPTS; p++) begin exp_res[p] = 0; exp_err[p] = 0; end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "request in reset", bus_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "results after reset", res_data, 0);
    chk("R1", "error flags after reset", res_err, 0);
    chk("R1", "update strobes after reset", res_upd, 0);

    // R3 R5 R6: four points, both code writes, high-level valid at bit 7
    need = '{1, 2, 3, 1};
    val = '{12'h123, 12'h456, 12'h789, 12'hABC};
    run(1, "four points");

    // R3 R5 R8: two points, first code write only, low-level valid at bit 3
    cfg_npts = 2; cfg_wr_ctl = 2'b01; cfg_valid_ctl = 6'b0_00011; cfg_poll_int = 5;
    need = '{2, 1, 1, 1};
    val = '{12'h0F1, 12'h0E2, 12'h333, 12'h444};
    run(1, "low level");

    // R7: timeout on point 1 keeps its old result
    cfg_npts = 3; cfg_wr_ctl = 2'b10; cfg_valid_ctl = 6'b1_11111; cfg_max_polls = 2; cfg_poll_int = 1;
    need = '{1, 5, 2, 1};
    val = '{12'h555, 12'h666, 12'h777, 12'h888};
    run(1, "timeout");

    // R8 zero count visits point 0 only; R10 flag of point 1 stays set
    cfg_npts = 0; cfg_wr_ctl = 2'b00; cfg_max_polls = 4;
    need = '{1, 1, 1, 1};
    val = '{12'h999, 12'h111, 12'h222, 12'h333};
    run(1, "single point");
    chk("R10", "point 1 flag sticky", res_err[1], 1);

    // R2 period, R8 clamp of 7 to four points, R10 flag cleared by success
    cfg_npts = 7; cfg_wr_ctl = 2'b11; cfg_unit = 1; cfg_sen_int = 3;
    val = '{12'hC01, 12'hC02, 12'hC03, 12'hC04};
    run(2, "two rounds");
    chk("R2", "round count", rstart.size(), 2);
    if (rstart.size() == 2) chk("R2", "round period", rstart[1] - rstart[0], 3 * 2 * 256);
    chk("R10", "point 1 flag cleared", res_err[1], 0);

    // R9 gap of two base ticks between points; R7 zero poll limit acts as one
    cfg_npts = 2; cfg_unit = 0; cfg_sen_int = 16; cfg_filt_int = 2; cfg_max_polls = 0;
    need = '{2, 1, 1, 1};
    val = '{12'hD0D, 12'hD1D, 12'hC03, 12'hC04};
    run(1, "filter gap");
    nvec++;
    if (!(last_gap > 256 && last_gap <= 520)) fail("R9", "inter-point gap", last_gap, 512);

    // R2 no requests while disabled
    req_seen = 0;
    repeat (3000) @(negedge clk);
    chk("R2", "requests while disabled", req_seen, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule